// File: doc/BRIEF.md
# MDIO Management Master with Software Pin Mode

This block is a small register-mapped controller for the two-wire management bus of an external Ethernet PHY. One control word selects between two ways of working. In the automatic mode the block assembles a complete clause-22 management frame from a PHY address, a register address and a read/write choice. It clocks the frame out on MDC/MDIO and, for a read, collects the sixteen bits the PHY returns. In the software pin mode the block stays out of the way: the control word sets the drive values and output enables of both pins directly, and software reads back the pin levels to run its own bit-banged protocol.

The CPU sees three word addresses: control (0), data (1) and status (2). A parameter selects a 16-bit or an 8-bit CPU bus, and the start rule follows the bus width. On a wide bus, writing the mode bit as 1 starts a frame. On a narrow bus, the low byte is written first, and a write to the high byte then starts the frame if the stored mode bit is already 1. MDC is the system clock divided by `2*HALF_DIV`, which keeps it at or below 2.5 MHz.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the control word is 0x0000, busy is 0, and both pin output enables are 0, so the block is in pin mode with nothing driven.
- R2: In pin mode (control bit 0 = 0) control bit 15 is the MDIO drive value, bit 14 is the MDC drive value, bit 13 enables the MDC driver and bit 12 enables the MDIO driver.
- R3: A read of the control word returns the MDIO pin level in bit 15, the MDC pin level in bit 14 and the stored bits 13:0.
- R4: With a 16-bit bus, a control write whose low lane is enabled and whose bit 0 is 1 starts a frame. A control write without the low lane, or with bit 0 = 0, starts nothing.
- R5: With an 8-bit bus, a control write on the high lane starts a frame only when the stored bit 0 is already 1. A low-lane write never starts one.
- R6: A frame is sent MSB first in this order: 32 ones, start bits 01, opcode 10 (read) or 01 (write), the 5-bit PHY address from control bits 6:2, the 5-bit register address from bits 11:7, turnaround, and 16 data bits. Control bit 1 = 1 selects read. A write frame carries turnaround 10 and the data word (address 1).
- R7: MDC has a period of 2*HALF_DIV clocks and makes exactly 64 rising edges per frame. It ends low.
- R8: MDIO output changes only on an MDC falling edge. Read data is sampled on MDC rising edges.
- R9: In a read frame the MDIO driver is off for the two turnaround bits and the 16 data bits, and the sampled bits are returned by a read of address 1.
- R10: Status bit 0 (address 2) is 1 from the start write until the last data bit completes. A start request made while it is 1 is ignored, and the frame in flight is unchanged.
- R11: While a frame is in flight the engine owns both pins, and writes to the control pin bits or the mode bit do not change the pins.
- R12: In automatic mode with no frame in flight, MDC is driven low and the MDIO driver is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Word address: 0 control, 1 data, 2 status |
| cpu_be | input | 2 | Byte lane enables (bit 0 low byte, bit 1 high byte) |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for cpu_addr (combinational) |
| mdc_o | output | 1 | MDC drive value |
| mdc_oe | output | 1 | MDC output enable |
| mdc_i | input | 1 | MDC pin level |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO pin level |

## Verification
The hardest case to reach is a control write that lands in the middle of a frame. A write may carry a fresh start request, or it may switch the mode to pin mode with the drivers off, while the engine is several MDC periods in. The stimulus waits on the bench's PHY model until it has counted ten MDC rising edges, then issues both writes. It then lets the frame run out and compares all 64 captured bits with the frame of the first command. Read returns come from the same PHY model, which drives each data bit by its MDC edge count, so the turnaround release and the sampling edge are both seen at the pins.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int FRAME_LEN = 64;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;
  localparam int WORD_W    = 16;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  typedef struct packed {
    logic              rd;
    logic [4:0]        phy;
    logic [4:0]        regn;
    logic [WORD_W-1:0] payload;
  } mdio_cmd_t;

  // Full serial image of one clause-22 frame, first bit in the MSB.
  function automatic logic [FRAME_LEN-1:0] build_frame(input mdio_cmd_t c);
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [WORD_W-1:0] dat;
    op  = c.rd ? 2'b10 : 2'b01;
    ta  = c.rd ? 2'b11 : 2'b10;
    dat = c.rd ? {WORD_W{1'b1}} : c.payload;
    return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regn, ta, dat};
  endfunction

  // Master drives every bit except turnaround and data of a read.
  function automatic logic master_drives(input logic rd, input logic [IDX_W-1:0] idx);
    return !(rd && (int'(idx) >= TA_POS));
  endfunction

  function automatic logic is_data_bit(input logic [IDX_W-1:0] idx);
    return int'(idx) >= DATA_POS;
  endfunction

endpackage

// File: rtl/mdio_phase_gen.sv
module mdio_phase_gen #(
  parameter int HALF_DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last  = (cnt == LAST);
  assign rise_evt = run && at_last && !mdc;
  assign fall_evt = run && at_last && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (at_last) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_in,
  output logic              busy,
  output logic              eng_rd,
  output logic [IDX_W-1:0]  idx,
  output logic              mdio_out,
  output logic              mdio_drv,
  output logic [WORD_W-1:0] rd_result
);
  logic [FRAME_LEN-1:0] shreg;
  logic                 last_bit;

  assign last_bit = (idx == IDX_W'(FRAME_LEN - 1));
  assign mdio_out = shreg[FRAME_LEN-1];
  assign mdio_drv = master_drives(eng_rd, idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      eng_rd    <= 1'b0;
      idx       <= '0;
      shreg     <= '0;
      rd_result <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      eng_rd <= cmd.rd;
      idx    <= '0;
      shreg  <= build_frame(cmd);
    end else if (busy) begin
      if (rise_evt && eng_rd && is_data_bit(idx))
        rd_result <= {rd_result[WORD_W-2:0], mdio_in};
      if (fall_evt) begin
        if (last_bit) begin
          busy <= 1'b0;
        end else begin
          idx   <= idx + 1'b1;
          shreg <= {shreg[FRAME_LEN-2:0], 1'b1};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_cpu_regs.sv
module mdio_cpu_regs
  import mdio_mgmt_pkg::*;
#(
  parameter bit BUS_16 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [1:0]        be,
  input  logic [WORD_W-1:0] wdata,
  input  logic              busy,
  input  logic [WORD_W-1:0] rd_result,
  input  logic              mdio_pin,
  input  logic              mdc_pin,
  output logic [WORD_W-1:0] ctrl,
  output mdio_cmd_t         cmd,
  output logic              start_req,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] payload;
  logic [WORD_W-1:0] ctrl_merged;
  logic [WORD_W-1:0] payload_merged;
  logic              ctrl_wr;
  logic              data_wr;

  assign ctrl_wr = wr && (addr == SEL_CTRL);
  assign data_wr = wr && (addr == SEL_DATA);

  // Value the registers hold after this cycle's write; a start uses it.
  always_comb begin
    ctrl_merged    = ctrl;
    payload_merged = payload;
    if (ctrl_wr && be[0]) ctrl_merged[7:0]     = wdata[7:0];
    if (ctrl_wr && be[1]) ctrl_merged[15:8]    = wdata[15:8];
    if (data_wr && be[0]) payload_merged[7:0]  = wdata[7:0];
    if (data_wr && be[1]) payload_merged[15:8] = wdata[15:8];
  end

  assign cmd = '{rd: ctrl_merged[1], phy: ctrl_merged[6:2],
                 regn: ctrl_merged[11:7], payload: payload_merged};

  generate
    if (BUS_16) begin : g_wide
      assign start_req = ctrl_wr && be[0] && wdata[0];
    end else begin : g_narrow
      assign start_req = ctrl_wr && be[1] && ctrl[0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      payload <= '0;
    end else begin
      ctrl    <= ctrl_merged;
      payload <= payload_merged;
    end
  end

  always_comb begin
    case (addr)
      SEL_CTRL: rdata = {mdio_pin, mdc_pin, ctrl[13:0]};
      SEL_DATA: rdata = rd_result;
      SEL_STAT: rdata = {{(WORD_W-1){1'b0}}, busy};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int HALF_DIV = 40,
  parameter bit BUS_16   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr,
  input  logic [1:0]  cpu_addr,
  input  logic [1:0]  cpu_be,
  input  logic [15:0] cpu_wdata,
  output logic [15:0] cpu_rdata,
  output logic        mdc_o,
  output logic        mdc_oe,
  input  logic        mdc_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              busy;
  logic              start_req;
  logic              rise_evt;
  logic              fall_evt;
  logic              eng_mdc;
  logic              eng_rd;
  logic              eng_mdio;
  logic              eng_drv;
  logic [IDX_W-1:0]  eng_idx;
  logic [WORD_W-1:0] ctrl;
  logic [WORD_W-1:0] rd_result;
  mdio_cmd_t         cmd;

  mdio_cpu_regs #(.BUS_16(BUS_16)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .addr(cpu_addr), .be(cpu_be),
    .wdata(cpu_wdata), .busy(busy), .rd_result(rd_result),
    .mdio_pin(mdio_i), .mdc_pin(mdc_i), .ctrl(ctrl), .cmd(cmd),
    .start_req(start_req), .rdata(cpu_rdata)
  );

  mdio_phase_gen #(.HALF_DIV(HALF_DIV)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(busy), .mdc(eng_mdc),
    .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_engine u_engine (
    .clk(clk), .rst_n(rst_n), .start(start_req), .cmd(cmd),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_in(mdio_i),
    .busy(busy), .eng_rd(eng_rd), .idx(eng_idx), .mdio_out(eng_mdio),
    .mdio_drv(eng_drv), .rd_result(rd_result)
  );

  always_comb begin
    if (busy) begin
      mdc_o   = eng_mdc;
      mdc_oe  = 1'b1;
      mdio_o  = eng_mdio;
      mdio_oe = eng_drv;
    end else if (ctrl[0]) begin
      mdc_o   = 1'b0;
      mdc_oe  = 1'b1;
      mdio_o  = 1'b1;
      mdio_oe = 1'b0;
    end else begin
      mdc_o   = ctrl[14];
      mdc_oe  = ctrl[13];
      mdio_o  = ctrl[15];
      mdio_oe = ctrl[12];
    end
  end
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       start_req,
  input logic       fall_evt,
  input logic       eng_mdc,
  input logic       eng_rd,
  input logic       eng_mdio,
  input logic [5:0] eng_idx,
  input logic       mdc_o,
  input logic       mdc_oe,
  input logic       mdio_oe
);
  p_pins_owned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mdc_oe);

  p_mdio_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(eng_mdio)) |-> $fell(mdc_o));

  p_ta_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_rd && (eng_idx >= 6'd46)) |-> !mdio_oe);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req && !fall_evt) |=> $stable(eng_idx));

  p_ends_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !eng_mdc);
endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start_req(start_req),
  .fall_evt(fall_evt), .eng_mdc(eng_mdc), .eng_rd(eng_rd),
  .eng_mdio(eng_mdio), .eng_idx(eng_idx), .mdc_o(mdc_o),
  .mdc_oe(mdc_oe), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_master_test.sv
`timescale 1ns/100ps
module mdio_mgmt_master_test;
  localparam int HALF = 3;
  localparam int NVEC = 4;
  // {rd, phy[4:0], reg[4:0], write data[15:0], PHY return data[15:0]}
  localparam logic [42:0] VEC [NVEC] = '{
    {1'b0, 5'h01, 5'h00, 16'hA5C3, 16'h0000},
    {1'b1, 5'h1F, 5'h02, 16'h0000, 16'h3C5A},
    {1'b0, 5'h10, 5'h1F, 16'hFFFF, 16'h0000},
    {1'b1, 5'h00, 5'h11, 16'h1234, 16'hC001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr16 = 1'b0, wr8 = 1'b0;
  logic [1:0] addr = '0, be = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata16, rdata8;
  logic mdc_o, mdc_oe, mdio_o, mdio_oe, mdc_i, mdio_i;
  logic m8_mdc_o, m8_mdc_oe, m8_mdio_o, m8_mdio_oe;

  logic phy_idle = 1'b0, mdc_ext = 1'b0, mon_en = 1'b0;
  logic [15:0] phy_val = '0;
  int rise_n = 0, bad_edges = 0;
  logic [63:0] frame_cap = '0, oe_cap = '0;
  realtime t_prev = 0, t_last = 0;
  logic prev_mdio = 1'b1;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    if (mdio_oe) mdio_i = mdio_o;
    else if (rise_n >= 48 && rise_n < 64) mdio_i = phy_val[15 - (rise_n - 48)];
    else mdio_i = phy_idle;
    mdc_i = mdc_oe ? mdc_o : mdc_ext;
  end

  mdio_mgmt_master #(.HALF_DIV(HALF), .BUS_16(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(wr16), .cpu_addr(addr), .cpu_be(be),
    .cpu_wdata(wdata), .cpu_rdata(rdata16), .mdc_o(mdc_o), .mdc_oe(mdc_oe),
    .mdc_i(mdc_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  mdio_mgmt_master #(.HALF_DIV(HALF), .BUS_16(1'b0)) uut_byte (
    .clk(clk), .rst_n(rst_n), .cpu_wr(wr8), .cpu_addr(addr), .cpu_be(be),
    .cpu_wdata(wdata), .cpu_rdata(rdata8), .mdc_o(m8_mdc_o), .mdc_oe(m8_mdc_oe),
    .mdc_i(1'b0), .mdio_o(m8_mdio_o), .mdio_oe(m8_mdio_oe), .mdio_i(1'b1));

  // PHY model: records every MDC rising edge.
  always @(posedge mdc_o) begin
    if (mdc_oe) begin
      frame_cap = {frame_cap[62:0], mdio_o};
      oe_cap    = {oe_cap[62:0], mdio_oe};
      rise_n    = rise_n + 1;
      t_prev    = t_last;
      t_last    = $realtime;
    end
  end

  always @(negedge clk) begin
    if (mon_en && (mdio_o !== prev_mdio) && mdc_o) bad_edges = bad_edges + 1;
    prev_mdio = mdio_o;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit byte_inst, input logic [1:0] a, input logic [1:0] lanes,
                    input logic [15:0] d);
    @(negedge clk);
    addr = a; be = lanes; wdata = d;
    wr16 = !byte_inst; wr8 = byte_inst;
    @(negedge clk);
    wr16 = 1'b0; wr8 = 1'b0; be = '0;
  endtask

  task automatic rd(input bit byte_inst, input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = byte_inst ? rdata8 : rdata16;
  endtask

  task automatic wait_idle(input bit byte_inst);
    logic [15:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(byte_inst, 2'd2, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic r, input logic [4:0] p,
                                            input logic [4:0] g, input logic [15:0] d);
    logic [63:0] f;
    f = 64'hFFFF_FFFF_0000_0000;
    f[31:30] = 2'b01;
    f[29:28] = r ? 2'b10 : 2'b01;
    f[27:23] = p;
    f[22:18] = g;
    f[17:16] = 2'b10;
    f[15:0]  = d;
    return f;
  endfunction

  task automatic start_txn(input logic r, input logic [4:0] p, input logic [4:0] g,
                           input logic [15:0] d, input logic [15:0] pv);
    phy_val = pv;
    rise_n = 0;
    wr(1'b0, 2'd1, 2'b11, d);
    wr(1'b0, 2'd0, 2'b11, {4'h0, g, p, r, 1'b1});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: all requirements, actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [63:0] ef;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 oe", {mdc_oe, mdio_oe, m8_mdc_oe, m8_mdio_oe}, 0);
    rd(1'b0, 2'd0, r); chk("R1 ctrl", r, 16'h0000);
    rd(1'b0, 2'd2, r); chk("R1 busy", r, 0);
    rd(1'b1, 2'd2, r); chk("R1 busy byte", r, 0);

    // Table of automatic frames: R6, R7, R9, R12
    mon_en = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      logic vr; logic [4:0] vp, vg; logic [15:0] vd, vpv;
      {vr, vp, vg, vd, vpv} = VEC[v];
      start_txn(vr, vp, vg, vd, vpv);
      wait_idle(1'b0);
      ef = exp_frame(vr, vp, vg, vd);
      chk("R7 rise count", rise_n, 64);
      chk("R7 period", 64'(int'(t_last - t_prev)), 2 * HALF * 5);
      if (vr) begin
        chk("R6 read frame", frame_cap[63:18], ef[63:18]);
        chk("R9 release", oe_cap, {{46{1'b1}}, 18'd0});
        rd(1'b0, 2'd1, r); chk("R9 read data", r, vpv);
      end else begin
        chk("R6 write frame", frame_cap, ef);
        chk("R9 write drive", oe_cap, {64{1'b1}});
      end
      rd(1'b0, 2'd2, r); chk("R10 busy clear", r, 0);
      chk("R12 idle pins", {mdc_oe, mdc_o, mdio_oe}, 3'b100);
    end

    // R10 / R11: writes in mid-frame
    start_txn(1'b0, 5'h03, 5'h04, 16'h0F0F, 16'h0);
    while (rise_n < 10) @(negedge clk);
    rd(1'b0, 2'd2, r); chk("R10 busy set", r, 1);
    wr(1'b0, 2'd0, 2'b11, 16'hF7FF);
    chk("R11 mdc owned", mdc_oe, 1'b1);
    wr(1'b0, 2'd0, 2'b11, 16'h0000);
    chk("R11 pins owned", {mdc_oe, mdio_oe}, 2'b11);
    wait_idle(1'b0);
    chk("R10 frame kept", frame_cap, exp_frame(1'b0, 5'h03, 5'h04, 16'h0F0F));
    chk("R8 mdio edges", bad_edges, 0);
    mon_en = 1'b0;
    chk("R2 released after", {mdc_oe, mdio_oe}, 2'b00);

    // R4: no start without bit 0 or low lane
    wr(1'b0, 2'd0, 2'b11, 16'h0006);
    rd(1'b0, 2'd2, r); chk("R4 bit0 clear", r, 0);
    wr(1'b0, 2'd0, 2'b10, 16'h0001);
    rd(1'b0, 2'd2, r); chk("R4 high lane only", r, 0);

    // R2: pin mode mapping
    wr(1'b0, 2'd0, 2'b11, 16'hF000);
    chk("R2 all on", {mdio_o, mdc_o, mdc_oe, mdio_oe}, 4'b1111);
    wr(1'b0, 2'd0, 2'b11, 16'h5000);
    chk("R2 mixed", {mdio_o, mdc_o, mdc_oe, mdio_oe}, 4'b0101);

    // R3: pin readback
    wr(1'b0, 2'd0, 2'b11, 16'h0000);
    phy_idle = 1'b1; mdc_ext = 1'b1;
    rd(1'b0, 2'd0, r); chk("R3 pins high", r, 16'hC000);
    phy_idle = 1'b0; mdc_ext = 1'b0;
    rd(1'b0, 2'd0, r); chk("R3 pins low", r, 16'h0000);
    wr(1'b0, 2'd0, 2'b11, 16'h3000);
    phy_idle = 1'b1;
    rd(1'b0, 2'd0, r); chk("R3 driven low", r, 16'h3000);

    // R5: narrow bus start rule
    wr(1'b1, 2'd0, 2'b01, 16'h0001);
    rd(1'b1, 2'd2, r); chk("R5 low byte no start", r, 0);
    wr(1'b1, 2'd0, 2'b10, 16'h0000);
    rd(1'b1, 2'd2, r); chk("R5 high byte start", r, 1);
    wait_idle(1'b1);
    wr(1'b1, 2'd0, 2'b01, 16'h0000);
    wr(1'b1, 2'd0, 2'b10, 16'h0000);
    rd(1'b1, 2'd2, r); chk("R5 mode clear no start", r, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule